// File: doc/BRIEF.md
# Parallel ADC Host Read Controller

This block sits on the host side of a parallel-output successive-approximation converter and runs it one conversion at a time. Each start request is served in the same order of steps. First a fixed acquisition interval passes with both strobes high. Then read/convert and chip select are driven low together for a short pulse to start the conversion. The controller waits for the converter's busy line to fall and then rise again. Finally it reads the result back through the same strobes.

The result is read in one of two ways. In word mode one read captures all sixteen bits. In byte mode two reads take the upper bus lane twice, and the byte-select line tells the converter which half to put there. The assembled word comes out with a one-cycle valid pulse. If busy fails to fall, or fails to rise again, within a timeout window, the controller gives up, pulses an error flag and returns to idle. A start request that arrives while a conversion is in flight is remembered and served afterwards. The busy input is assumed to be already synchronous to the clock.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, cs_n and rc are 1, byte_sel, sample_valid and timeout_err are 0, and sample is zero.
- R2: After a start is accepted from idle, rc and cs_n both stay high for exactly ACQ_CYC cycles. They then go low together for exactly CONV_LO_CYC cycles. rc is never low unless cs_n is low. At least ACQ_CYC cycles separate any rise of busy_n from the next fall of rc.
- R3: While the controller waits for busy_n to fall and to rise, cs_n and rc are both high, so at every rising edge of busy_n at least one strobe is high.
- R4: The read strobe (cs_n low, rc high) is asserted only after busy_n has risen. In word mode a single read of ACCESS_CYC cycles is made with byte_sel 0, and sample takes all of data_in as sampled in its last cycle. sample changes in no cycle in which cs_n is high.
- R5: In byte mode, a read of ACCESS_CYC cycles with byte_sel 0 takes data_in[15:8] into sample[15:8]. It is followed by a read of ACCESS_CYC cycles with byte_sel 1 that takes data_in[15:8] into sample[7:0]. data_in[7:0] has no effect in byte mode. byte_sel is 1 only during that second read.
- R6: sample_valid is 1 for exactly one cycle per completed conversion, in the cycle after the last read, with cs_n and rc both high. sample holds its value in the following cycle.
- R7: If busy_n does not fall within TIMEOUT_CYC cycles after the convert pulse, or does not rise within TIMEOUT_CYC cycles after falling, timeout_err is 1 for one cycle and no sample_valid is produced for that request. The strobes return high and the controller accepts the next request.
- R8: A start asserted while the controller is not idle is held pending and served by exactly one further conversion, however many such starts arrive.
- R9: byte_mode is taken when a request is accepted. Changing it later has no effect on the reads of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request |
| busy_n | input | 1 | Converter status, low while converting |
| byte_mode | input | 1 | 1: assemble result from two upper-lane byte reads |
| data_in | input | DATA_W (16) | Converter data bus |
| cs_n | output | 1 | Chip select, active low |
| rc | output | 1 | Read/convert: low starts conversion, high reads |
| byte_sel | output | 1 | Byte swap select to the converter |
| sample | output | DATA_W (16) | Assembled conversion result |
| sample_valid | output | 1 | One-cycle pulse when sample is new |
| timeout_err | output | 1 | One-cycle pulse when busy_n fails to move in time |

## Verification
The assertions check strobe hygiene on every cycle. rc is never low without chip select, and a strobe is high at every busy_n rise. byte_sel appears only during a read. sample_valid and timeout_err each last a single cycle and never coincide, and the result register does not move outside a read. The bench scenarios cover what needs whole transactions. These are the exact acquisition and pulse lengths, the assembled values in word and byte mode with a garbage low lane, the late byte_mode change, the collapse of several pending starts into one extra conversion, and recovery from both kinds of stuck busy line.

// File: rtl/adc_rd_pkg.sv
// Shared types for the parallel ADC host read controller.
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // no request in flight
        ST_ACQ,      // strobes high, input settling
        ST_CONV,     // cs_n and rc low: conversion start pulse
        ST_WLOW,     // waiting for busy_n to fall
        ST_WHIGH,    // waiting for busy_n to rise
        ST_RDHI,     // first (or only) read
        ST_RDLO,     // second read, byte mode only
        ST_DONE      // strobes released, result valid
    } rd_state_t;
endpackage

// File: rtl/adc_rd_timer.sv
// In-state cycle counter.
// Counts cycles since the last clear and saturates at all ones.
// Assumes clr is raised on the cycle a state is left.
module adc_rd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // count up, restart on clear, hold at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_rd_assemble.sv
// Result register.
// Loads the whole bus in word mode. In byte mode it loads the upper bus
// lane into either half of the word.
// Assumes at most one capture strobe is high in any cycle.
module adc_rd_assemble #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_word,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] sample
);
    localparam int LANE_W = DATA_W / 2;

    logic [LANE_W-1:0] lane_up;
    assign lane_up = data_in[DATA_W-1:LANE_W];

    // capture the selected part of the bus into the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
        end else if (cap_word) begin
            sample <= data_in;
        end else if (cap_hi) begin
            sample[DATA_W-1:LANE_W] <= lane_up;
        end else if (cap_lo) begin
            sample[LANE_W-1:0] <= lane_up;
        end
    end
endmodule

// File: rtl/adc_rd_fsm.sv
// Sequencer for one conversion and read-back.
// It runs acquisition, the convert pulse, the busy handshake with a
// timeout, then one or two reads and the valid cycle.
// Assumes busy_n is synchronous to clk and every cycle parameter is >= 1.
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int ACQ_CYC     = 200,
    parameter int CONV_LO_CYC = 4,
    parameter int ACCESS_CYC  = 3,
    parameter int TIMEOUT_CYC = 2000,
    parameter int CNT_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             busy_n,
    input  logic             byte_mode,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cs_n,
    output logic             rc,
    output logic             byte_sel,
    output logic             cap_word,
    output logic             cap_hi,
    output logic             cap_lo,
    output logic             sample_valid,
    output logic             timeout_err
);
    localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYC - 1);
    localparam logic [CNT_W-1:0] CNV_LAST = CNT_W'(CONV_LO_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);

    rd_state_t state, state_n;
    logic      pend;
    logic      mode_q;
    logic      take;
    logic      tmo_hit;
    logic      acc_end;

    assign take    = (state == ST_IDLE) && (start || pend);
    assign acc_end = (cnt == ACC_LAST);
    assign tmo_hit = (cnt == TMO_LAST) &&
                     (((state == ST_WLOW) && busy_n) ||
                      ((state == ST_WHIGH) && !busy_n));

    // next-state selection
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (take) state_n = ST_ACQ;
            ST_ACQ:   if (cnt == ACQ_LAST) state_n = ST_CONV;
            ST_CONV:  if (cnt == CNV_LAST) state_n = ST_WLOW;
            ST_WLOW:  if (!busy_n) state_n = ST_WHIGH;
                      else if (tmo_hit) state_n = ST_IDLE;
            ST_WHIGH: if (busy_n) state_n = ST_RDHI;
                      else if (tmo_hit) state_n = ST_IDLE;
            ST_RDHI:  if (acc_end) state_n = mode_q ? ST_RDLO : ST_DONE;
            ST_RDLO:  if (acc_end) state_n = ST_DONE;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // remember starts that arrive while a request is in flight
    always_ff @(posedge clk) begin
        if (!rst_n)                        pend <= 1'b0;
        else if (take)                     pend <= 1'b0;
        else if (start && state != ST_IDLE) pend <= 1'b1;
    end

    // latch the read mode when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= 1'b0;
        else if (take) mode_q <= byte_mode;
    end

    // one-cycle error pulse on a busy timeout
    always_ff @(posedge clk) begin
        if (!rst_n) timeout_err <= 1'b0;
        else        timeout_err <= tmo_hit;
    end

    // strobe and capture decode from the state register
    always_comb begin
        cnt_clr      = (state_n != state);
        cs_n         = !((state == ST_CONV) || (state == ST_RDHI) || (state == ST_RDLO));
        rc           = (state != ST_CONV);
        byte_sel     = (state == ST_RDLO);
        cap_word     = (state == ST_RDHI) && acc_end && !mode_q;
        cap_hi       = (state == ST_RDHI) && acc_end && mode_q;
        cap_lo       = (state == ST_RDLO) && acc_end;
        sample_valid = (state == ST_DONE);
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
// Top of the parallel ADC host read controller.
// Joins the sequencer, the in-state counter and the result register.
// Assumes DATA_W is even and busy_n is already synchronous to clk.
module adc_rd_ctrl #(
    parameter int DATA_W      = 16,
    parameter int ACQ_CYC     = 200,
    parameter int CONV_LO_CYC = 4,
    parameter int ACCESS_CYC  = 3,
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy_n,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] data_in,
    output logic              cs_n,
    output logic              rc,
    output logic              byte_sel,
    output logic [DATA_W-1:0] sample,
    output logic              sample_valid,
    output logic              timeout_err
);
    localparam int MAX_A   = (ACQ_CYC > TIMEOUT_CYC) ? ACQ_CYC : TIMEOUT_CYC;
    localparam int MAX_B   = (CONV_LO_CYC > ACCESS_CYC) ? CONV_LO_CYC : ACCESS_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cap_word, cap_hi, cap_lo;

    adc_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    adc_rd_fsm #(
        .ACQ_CYC     (ACQ_CYC),
        .CONV_LO_CYC (CONV_LO_CYC),
        .ACCESS_CYC  (ACCESS_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .busy_n       (busy_n),
        .byte_mode    (byte_mode),
        .cnt          (cnt),
        .cnt_clr      (cnt_clr),
        .cs_n         (cs_n),
        .rc           (rc),
        .byte_sel     (byte_sel),
        .cap_word     (cap_word),
        .cap_hi       (cap_hi),
        .cap_lo       (cap_lo),
        .sample_valid (sample_valid),
        .timeout_err  (timeout_err)
    );

    adc_rd_assemble #(.DATA_W(DATA_W)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_word (cap_word),
        .cap_hi   (cap_hi),
        .cap_lo   (cap_lo),
        .data_in  (data_in),
        .sample   (sample)
    );
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
// Property checker for adc_rd_ctrl, attached with bind.
// It observes the top-level ports only.
module adc_rd_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_n,
    input logic              cs_n,
    input logic              rc,
    input logic              byte_sel,
    input logic [DATA_W-1:0] sample,
    input logic              sample_valid,
    input logic              timeout_err
);
    // R1: the cycle after a reset cycle shows idle strobes and no pulses
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cs_n && rc && !byte_sel && !sample_valid && !timeout_err));

    // R2: convert pulse only with chip select
    p_rc_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rc |-> !cs_n);

    // R3: a strobe is high whenever busy_n rises
    p_strobe_at_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (cs_n || rc));

    // R4: result register moves only during a read
    p_sample_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(sample));

    // R5: byte swap only during a read
    p_bytesel_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sel |-> (!cs_n && rc));

    // R6: valid is a single cycle with strobes released
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);
    p_valid_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (cs_n && rc));

    // R7: error is a single cycle and never meets a valid
    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);
    p_err_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_err && sample_valid));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_n       (busy_n),
    .cs_n         (cs_n),
    .rc           (rc),
    .byte_sel     (byte_sel),
    .sample       (sample),
    .sample_valid (sample_valid),
    .timeout_err  (timeout_err)
);

// File: tb/adc_rd_ctrl_test.sv
// Scoreboard bench for adc_rd_ctrl with a behavioural converter model.
module adc_rd_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int ACQ        = 12;
    localparam int CLO        = 4;
    localparam int ACC        = 3;
    localparam int TMO        = 100;
    localparam int BUSY_LEN   = 30;

    typedef struct {
        logic [DW-1:0] word;
        bit            bmode;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy_n = 1'b1;
    logic          byte_mode = 1'b0;
    logic [DW-1:0] data_in = 16'h5A5A;
    logic          cs_n, rc, byte_sel, sample_valid, timeout_err;
    logic [DW-1:0] sample;

    int checks = 0;
    int failures = 0;

    exp_t          exp_q[$];
    logic [DW-1:0] adc_q[$];

    // converter model state
    int            ncyc = 0;
    int            conv_cnt = 0;
    int            err_cnt = 0;
    int            valid_cnt = 0;
    int            rd_hi_cnt = 0;
    int            rd_lo_cnt = 0;
    int            last_rise = 0;
    bit            have_rise = 0;
    bit            stuck_hi = 0;
    bit            stuck_lo = 0;
    bit            lo_junk = 0;
    logic [DW-1:0] word_cur = '0;

    adc_rd_ctrl #(
        .DATA_W(DW), .ACQ_CYC(ACQ), .CONV_LO_CYC(CLO),
        .ACCESS_CYC(ACC), .TIMEOUT_CYC(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy_n(busy_n),
        .byte_mode(byte_mode), .data_in(data_in), .cs_n(cs_n), .rc(rc),
        .byte_sel(byte_sel), .sample(sample), .sample_valid(sample_valid),
        .timeout_err(timeout_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // converter model: acts on the negative edge, away from the design's edge
    initial begin : adc_model
        bit prev_rc = 1'b1;
        bit conv_act = 0;
        int dly = 0;
        int left = 0;
        int lo_run = 0;
        forever begin
            @(negedge clk);
            ncyc++;
            if (rst_n) begin
                if (!rc && prev_rc && !cs_n) begin
                    conv_cnt++;
                    rd_hi_cnt = 0;
                    rd_lo_cnt = 0;
                    check(busy_n == 1'b1, "R3 no restart while converting", busy_n, 1);
                    if (have_rise)
                        check(ncyc - last_rise >= ACQ, "R2 acquisition gap", ncyc - last_rise, ACQ);
                    word_cur = (adc_q.size() > 0) ? adc_q.pop_front() : 16'h0BAD;
                    if (!stuck_hi) begin
                        conv_act = 1;
                        dly = 2;
                    end
                end
                if (!rc) lo_run++;
                else if (lo_run > 0) begin
                    check(lo_run == CLO, "R2 convert pulse width", lo_run, CLO);
                    lo_run = 0;
                end
                if (!cs_n && rc) begin
                    check(busy_n == 1'b1, "R4 read after busy rise", busy_n, 1);
                    if (byte_sel) rd_lo_cnt++;
                    else          rd_hi_cnt++;
                end
                if (conv_act) begin
                    if (dly > 0) begin
                        dly--;
                        if (dly == 0) begin
                            busy_n = 1'b0;
                            left = BUSY_LEN;
                        end
                    end else if (left > 0) begin
                        left--;
                    end else if (!stuck_lo) begin
                        check(cs_n || rc, "R3 strobe high at busy rise", {cs_n, rc}, 1);
                        busy_n = 1'b1;
                        conv_act = 0;
                        last_rise = ncyc;
                        have_rise = 1;
                    end
                end
            end
            prev_rc = rc;
            if (!cs_n && rc)
                data_in = byte_sel ? {word_cur[7:0], word_cur[15:8]} : word_cur;
            else
                data_in = 16'h5A5A;
            if (lo_junk) data_in[7:0] = 8'hC3;
        end
    end

    // monitor: pops expected results and compares them as they appear
    initial begin : monitor
        bit            chk_next = 0;
        logic [DW-1:0] held = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (chk_next) begin
                    check(!sample_valid, "R6 valid lasts one cycle", sample_valid, 0);
                    check(sample == held, "R6 sample held", sample, held);
                    chk_next = 0;
                end
                if (timeout_err) err_cnt++;
                if (sample_valid) begin
                    valid_cnt++;
                    check(cs_n && rc, "R6 strobes released at valid", {cs_n, rc}, 3);
                    if (exp_q.size() == 0) begin
                        check(0, "R7 unexpected sample_valid", sample, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (e.bmode) begin
                            check(sample == e.word, "R5 byte-mode word", sample, e.word);
                            check(rd_lo_cnt == ACC, "R5 R9 second read length", rd_lo_cnt, ACC);
                        end else begin
                            check(sample == e.word, "R4 word-mode word", sample, e.word);
                            check(rd_lo_cnt == 0, "R4 R9 no second read", rd_lo_cnt, 0);
                        end
                        check(rd_hi_cnt == ACC, "R4 first read length", rd_hi_cnt, ACC);
                    end
                    held = sample;
                    chk_next = 1;
                end
            end
        end
    end

    // driver: queue one expected result and pulse start
    task automatic push_req(input logic [DW-1:0] w, input bit bm);
        exp_t e;
        e.word = w;
        e.bmode = bm;
        exp_q.push_back(e);
        adc_q.push_back(w);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // driver: single request from idle, timing the acquisition window
    task automatic conv_timed(input logic [DW-1:0] w, input bit bm);
        int n;
        push_req(w, bm);
        byte_mode = bm;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (rc && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == ACQ + 1, "R2 acquisition length from start", n, ACQ + 1);
        drain();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int c0, e0, v0;
        repeat (5) @(negedge clk);
        // R1 reset values
        check(cs_n && rc, "R1 strobes high in reset", {cs_n, rc}, 3);
        check(!byte_sel && !sample_valid && !timeout_err, "R1 flags low in reset",
              {byte_sel, sample_valid, timeout_err}, 0);
        check(sample == '0, "R1 sample zero in reset", sample, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // word and byte mode patterns
        conv_timed(16'h1234, 0);
        lo_junk = 1;
        conv_timed(16'hBEEF, 1);
        conv_timed(16'h7FFE, 1);
        conv_timed(16'h0001, 1);
        lo_junk = 0;
        conv_timed(16'h0000, 0);
        conv_timed(16'hFFFF, 0);
        conv_timed(16'h8001, 0);

        // R9: mode change after acceptance has no effect
        push_req(16'h3C5A, 1);
        byte_mode = 1'b1;
        pulse_start();
        byte_mode = 1'b0;
        drain();
        push_req(16'hA1B2, 0);
        byte_mode = 1'b0;
        pulse_start();
        byte_mode = 1'b1;
        drain();
        byte_mode = 1'b0;

        // R8: several starts during a conversion give one more conversion
        c0 = conv_cnt;
        push_req(16'h1111, 0);
        push_req(16'h2222, 0);
        pulse_start();
        while (busy_n) @(negedge clk);
        pulse_start();
        repeat (2) @(negedge clk);
        pulse_start();
        drain();
        repeat (ACQ + 60) @(negedge clk);
        check(conv_cnt - c0 == 2, "R8 pending starts collapse to one", conv_cnt - c0, 2);

        // R7: busy never falls
        e0 = err_cnt;
        v0 = valid_cnt;
        stuck_hi = 1;
        adc_q.push_back(16'hDEAD);
        pulse_start();
        repeat (ACQ + CLO + TMO + 20) @(negedge clk);
        check(err_cnt - e0 == 1, "R7 timeout on busy not falling", err_cnt - e0, 1);
        check(valid_cnt == v0, "R7 no valid after timeout", valid_cnt, v0);
        check(cs_n && rc, "R7 strobes high after timeout", {cs_n, rc}, 3);
        stuck_hi = 0;

        // R7: busy never rises, then recovery
        e0 = err_cnt;
        stuck_lo = 1;
        adc_q.push_back(16'hDEAD);
        pulse_start();
        repeat (ACQ + CLO + TMO + 20) @(negedge clk);
        check(err_cnt - e0 == 1, "R7 timeout on busy not rising", err_cnt - e0, 1);
        check(valid_cnt == v0, "R7 no valid after second timeout", valid_cnt, v0);
        stuck_lo = 0;
        repeat (5) @(negedge clk);
        conv_timed(16'hA55A, 0);
        check(valid_cnt == v0 + 1, "R7 accepts next request", valid_cnt, v0 + 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule